// File: doc/BRIEF.md
# At-Speed Transition Test Sequencer

This controller runs one transition-delay test on a scan chain. After a start request it loads the chain with a programmed number of shift cycles. It then issues a launch pulse, a capture pulse one cycle later, and a one-cycle completion flag. Two launch methods are available, chosen when the run starts.

In launch-on-shift, the launch is one extra shift, so the launching value comes in through the scan-in path. Scan enable must then drop between launch and capture at functional speed. In launch-on-capture, scan enable drops right after loading and stays low for a programmable idle gap. The launch and the capture are then two functional clock pulses, back to back, with the launching value coming through the functional data path.

A staged copy of scan enable is also produced. It is a flop pipeline that lets the signal be distributed across a large chain at speed. All pins are plain control and status levels. There is no streamed data, so there is no valid/ready handshake.

Top module: `at_speed_seq`

## Requirements
- R1: An asynchronous active-low reset forces the controller idle. While reset is held, every output, including the staged scan enable, is low.
- R2: A start is accepted only when the controller is idle, `test_en` is high and `shift_len` is nonzero. `shift_len` and `mode_los` are captured at that edge. During the next `shift_len` cycles, `shift_pulse` and `scan_en` are both high.
- R3: With `mode_los`=1 (launch-on-shift), the cycle after the last shift has `launch_pulse` high with `scan_en` still high. In the following cycle `capture_pulse` is high and `scan_en` is low.
- R4: With `mode_los`=0 (launch-on-capture), the last shift is followed by `GAP_CYCLES` cycles (default 1, at least 1) in which all outputs are low. Then comes `launch_pulse` with `scan_en` low, and then `capture_pulse` with `scan_en` low.
- R5: `capture_pulse` comes exactly one cycle after `launch_pulse` in both modes. At most one of `shift_pulse`, `launch_pulse`, `capture_pulse` and `done` is high in any cycle.
- R6: `done` is high for exactly one cycle, the cycle after the capture. The controller is idle from the next cycle on, and a new start can be accepted from then.
- R7: A start sampled while a run is in progress has no effect. A change of `shift_len` or `mode_los` during a run also has no effect on the running sequence.
- R8: While `test_en` is low, every output is low in that same cycle and starts are ignored. If `test_en` drops during a run, the controller is idle at the next edge.
- R9: A start with `shift_len` equal to zero is ignored, and no pulse follows it.
- R10: `scan_en_staged` equals `scan_en` delayed by `SE_STAGES` cycles (default 2). Its stages are cleared while `test_en` is low.
- R11: The shift length spans 1 to 2^`LEN_W`-1 cycles (1023 by default). Both ends of that range give exactly that number of shift pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test-mode enable; low holds the block idle and silent |
| start | input | 1 | Request to begin one load/launch/capture run |
| mode_los | input | 1 | 1 = launch-on-shift, 0 = launch-on-capture |
| shift_len | input | LEN_W | Number of load shift cycles |
| scan_en | output | 1 | Scan enable |
| scan_en_staged | output | 1 | Scan enable through SE_STAGES flops |
| shift_pulse | output | 1 | Shift clock request |
| launch_pulse | output | 1 | Launch clock request |
| capture_pulse | output | 1 | Capture clock request |
| done | output | 1 | One-cycle end-of-run flag |

## Verification
A corrupted phase register shows up at once as a pulse whose scan-enable level is wrong for its mode. The bench's chain model then captures a different word, and that word is visible one cycle after the capture. A wrong shift counter moves the launch earlier or later by one cycle per count of error. This is seen at the first cycle where the pulse pattern departs from the expected sequence of length N plus three or four. A stale gap counter or staged enable stage appears as a missing idle cycle, or as a staged output that differs from the enable two cycles earlier.

// File: rtl/atseq_pkg.sv
package atseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_GAP    = 3'd2,
    ST_LAUNCH = 3'd3,
    ST_CAPT   = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_t;

  typedef enum logic {
    MODE_LOC = 1'b0,
    MODE_LOS = 1'b1
  } launch_mode_t;
endpackage

// File: rtl/atseq_down_counter.sv
module atseq_down_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clr)      count <= '0;
    else if (load)     count <= load_val;
    else if (dec && count != '0) count <= count - ONE;
  end

  assign last = (count == ONE);

  // R2: the sequencer never asks for a decrement past zero
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !load) |-> (count != '0));
endmodule

// File: rtl/atseq_se_pipe.sv
module atseq_se_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic se_in,
  output logic se_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign se_out = se_in;
    end else begin : g_stages
      logic [STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stg <= '0;
        else if (flush) stg <= '0;
        else if (STAGES == 1) stg <= se_in;
        else            stg <= {stg[STAGES-2:0], se_in} & {STAGES{1'b1}};
      end
      assign se_out = stg[STAGES-1];

      // R10: a flush leaves the staged output low on the next cycle
      p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !se_out);
    end
  endgenerate
endmodule

// File: rtl/atseq_fsm.sv
module atseq_fsm
  import atseq_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int GAP_CYCLES = 1,
  parameter int GAP_W      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             start,
  input  logic             mode_los,
  input  logic [LEN_W-1:0] shift_len,
  input  logic             len_last,
  input  logic             gap_last,
  output logic             len_load,
  output logic             len_dec,
  output logic             gap_load,
  output logic             gap_dec,
  output logic             scan_en,
  output logic             shift_pulse,
  output logic             launch_pulse,
  output logic             capture_pulse,
  output logic             done
);
  seq_state_t   state_q, state_d;
  launch_mode_t mode_q;
  logic         accept;

  assign accept = test_en && start && (state_q == ST_IDLE) && (shift_len != '0);

  always_comb begin
    state_d  = state_q;
    len_load = 1'b0;
    len_dec  = 1'b0;
    gap_load = 1'b0;
    gap_dec  = 1'b0;
    if (!test_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_d  = ST_SHIFT;
            len_load = 1'b1;
          end
        end
        ST_SHIFT: begin
          len_dec = 1'b1;
          if (len_last) begin
            if (mode_q == MODE_LOS) begin
              state_d = ST_LAUNCH;
            end else begin
              state_d  = ST_GAP;
              gap_load = 1'b1;
            end
          end
        end
        ST_GAP: begin
          gap_dec = 1'b1;
          if (gap_last) state_d = ST_LAUNCH;
        end
        ST_LAUNCH: state_d = ST_CAPT;
        ST_CAPT:   state_d = ST_DONE;
        ST_DONE:   state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_LOC;
    end else begin
      state_q <= state_d;
      if (accept) mode_q <= launch_mode_t'(mode_los);
    end
  end

  assign scan_en       = test_en && ((state_q == ST_SHIFT) ||
                         (state_q == ST_LAUNCH && mode_q == MODE_LOS));
  assign shift_pulse   = test_en && (state_q == ST_SHIFT);
  assign launch_pulse  = test_en && (state_q == ST_LAUNCH);
  assign capture_pulse = test_en && (state_q == ST_CAPT);
  assign done          = test_en && (state_q == ST_DONE);

  // R8: dropping test mode returns the sequencer to idle
  p_test_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (state_q == ST_IDLE));

  // R7: the launch method cannot change while a run is in progress
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(mode_q));

  // R4: in launch-on-capture a shift is never directly followed by a launch
  p_loc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n || !test_en)
    (shift_pulse && mode_q == MODE_LOC) |=> !launch_pulse);

  // R6: done is followed by idle
  p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_q == ST_IDLE));
endmodule

// File: rtl/at_speed_seq.sv
module at_speed_seq #(
  parameter int LEN_W      = 10,
  parameter int GAP_CYCLES = 1,
  parameter int SE_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             start,
  input  logic             mode_los,
  input  logic [LEN_W-1:0] shift_len,
  output logic             scan_en,
  output logic             scan_en_staged,
  output logic             shift_pulse,
  output logic             launch_pulse,
  output logic             capture_pulse,
  output logic             done
);
  localparam int GAP_N = (GAP_CYCLES < 1) ? 1 : GAP_CYCLES;
  localparam int GAP_W = $clog2(GAP_N + 1);

  logic             len_load, len_dec, len_last;
  logic             gap_load, gap_dec, gap_last;
  logic [LEN_W-1:0] len_count;
  logic [GAP_W-1:0] gap_count;

  atseq_fsm #(
    .LEN_W(LEN_W), .GAP_CYCLES(GAP_N), .GAP_W(GAP_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
    .mode_los(mode_los), .shift_len(shift_len),
    .len_last(len_last), .gap_last(gap_last),
    .len_load(len_load), .len_dec(len_dec),
    .gap_load(gap_load), .gap_dec(gap_dec),
    .scan_en(scan_en), .shift_pulse(shift_pulse),
    .launch_pulse(launch_pulse), .capture_pulse(capture_pulse), .done(done)
  );

  atseq_down_counter #(.W(LEN_W)) u_len_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!test_en), .load(len_load),
    .load_val(shift_len), .dec(len_dec), .count(len_count), .last(len_last)
  );

  atseq_down_counter #(.W(GAP_W)) u_gap_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!test_en), .load(gap_load),
    .load_val(GAP_W'(GAP_N)), .dec(gap_dec), .count(gap_count), .last(gap_last)
  );

  atseq_se_pipe #(.STAGES(SE_STAGES)) u_se_pipe (
    .clk(clk), .rst_n(rst_n), .flush(!test_en),
    .se_in(scan_en), .se_out(scan_en_staged)
  );

  // R5: pulse types and done are mutually exclusive
  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_pulse, launch_pulse, capture_pulse, done}));

  // R5: capture follows launch by exactly one cycle
  p_capt_after_launch_r5: assert property (@(posedge clk) disable iff (!rst_n || !test_en)
    launch_pulse |=> capture_pulse);

  // R3: scan enable drops at speed between a shift-launch and its capture
  p_los_drop_r3: assert property (@(posedge clk) disable iff (!rst_n || !test_en)
    (launch_pulse && scan_en) |=> (capture_pulse && !scan_en));

  // R2: a shift is only requested while the length counter holds work
  p_shift_has_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |-> (len_count != '0));

  // R4: the gap counter never exceeds its programmed length
  p_gap_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_count <= GAP_W'(GAP_N));
endmodule

// File: tb/at_speed_seq_test.sv
module at_speed_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 10;
  localparam int GAP = 1;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0;
  logic start = 1'b0;
  logic mode_los = 1'b0;
  logic [LEN_W-1:0] shift_len = '0;
  logic scan_en, scan_en_staged, shift_pulse, launch_pulse, capture_pulse, done;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  at_speed_seq #(.LEN_W(LEN_W), .GAP_CYCLES(GAP), .SE_STAGES(STG)) uut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
    .mode_los(mode_los), .shift_len(shift_len),
    .scan_en(scan_en), .scan_en_staged(scan_en_staged),
    .shift_pulse(shift_pulse), .launch_pulse(launch_pulse),
    .capture_pulse(capture_pulse), .done(done)
  );

  // small scan chain model: shift when scan_en, else functional load q^1010
  logic [3:0] chain = 4'b0000;
  logic chain_clr = 1'b0;
  always_ff @(posedge clk) begin
    if (chain_clr) chain <= 4'b0000;
    else if (shift_pulse || launch_pulse || capture_pulse) begin
      if (scan_en) chain <= {chain[2:0], 1'b1};
      else         chain <= chain ^ 4'b1010;
    end
  end

  function automatic logic [4:0] outs();
    return {scan_en, shift_pulse, launch_pulse, capture_pulse, done};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic pulse_start(input logic m, input int len);
    mode_los  = m;
    shift_len = LEN_W'(len);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  // Runs one sequence and checks every cycle against the expected pattern.
  task automatic t_seq(input logic m, input int len, input logic poke, input string tag);
    logic [4:0] exp;
    logic se_d1, se_d2;
    int total, bad_k, bad_pipe;
    logic [4:0] bad_act, bad_exp;
    logic [3:0] exp_chain;
    chain_clr = 1'b1;
    @(negedge clk);
    chain_clr = 1'b0;
    se_d1 = 1'b0; se_d2 = 1'b0;
    bad_k = 0; bad_pipe = 0; bad_act = '0; bad_exp = '0;
    total = m ? len + 3 : len + GAP + 3;
    pulse_start(m, len);
    for (int k = 1; k <= total + 1; k++) begin
      if (k <= len)                   exp = 5'b11000;
      else if (m && k == len + 1)     exp = 5'b10100;
      else if (k == total - 1)        exp = 5'b00010;
      else if (k == total)            exp = 5'b00001;
      else if (!m && k == total - 2)  exp = 5'b00100;
      else                            exp = 5'b00000;
      if (outs() !== exp && bad_k == 0) begin
        bad_k = k; bad_act = outs(); bad_exp = exp;
      end
      if (scan_en_staged !== se_d2 && bad_pipe == 0) bad_pipe = k;
      se_d2 = se_d1;
      se_d1 = scan_en;
      if (poke && k == 2) begin
        start = 1'b1; shift_len = LEN_W'(len + 4); mode_los = ~m;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check(bad_k == 0, m ? "R3" : "R4", {tag, " cycle pattern"}, bad_act, bad_exp);
    check(bad_pipe == 0, "R10", {tag, " staged scan enable"}, bad_pipe, 0);
    exp_chain = m ? 4'b0101 : 4'b0111;
    if (len != 3) exp_chain = chain;
    check(chain == exp_chain, "R5", {tag, " chain capture"}, chain, exp_chain);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(outs() == 5'b0 && scan_en_staged == 1'b0, "R1", "outputs in reset",
          {outs(), scan_en_staged}, 0);
    rst_n = 1'b1;
    test_en = 1'b1;
    @(negedge clk);
    check(outs() == 5'b0, "R1", "idle after reset", outs(), 0);
  endtask

  task automatic t_zero_len();
    pulse_start(1'b1, 0);
    for (int k = 0; k < 3; k++) begin
      if (outs() != 5'b0) begin
        check(1'b0, "R9", "zero length start", outs(), 0);
        return;
      end
      @(negedge clk);
    end
    check(1'b1, "R9", "zero length start", 0, 0);
  endtask

  task automatic t_test_off();
    test_en = 1'b0;
    pulse_start(1'b1, 4);
    check(outs() == 5'b0, "R8", "start with test_en low", outs(), 0);
    test_en = 1'b1;
    @(negedge clk);
    check(outs() == 5'b0, "R8", "no pending run after enable", outs(), 0);
    pulse_start(1'b0, 6);
    @(negedge clk);
    check(shift_pulse == 1'b1, "R2", "shifting before abort", shift_pulse, 1);
    test_en = 1'b0;
    #1;
    check(outs() == 5'b0, "R8", "outputs drop with test_en", outs(), 0);
    @(negedge clk);
    test_en = 1'b1;
    #1;
    check(outs() == 5'b0 && scan_en_staged == 1'b0, "R8", "idle after abort",
          {outs(), scan_en_staged}, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_async_reset();
    pulse_start(1'b1, 5);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(scan_en == 1'b0 && shift_pulse == 1'b0 && scan_en_staged == 1'b0, "R1",
          "async reset mid run", {scan_en, shift_pulse, scan_en_staged}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() == 5'b0, "R1", "idle after mid-run reset", outs(), 0);
  endtask

  task automatic t_back_to_back();
    int cnt;
    cnt = 0;
    pulse_start(1'b1, 2);
    // shifts at 1,2; launch 3; capture 4; done 5
    for (int k = 1; k < 5; k++) @(negedge clk);
    check(done == 1'b1, "R6", "done cycle", done, 1);
    pulse_start(1'b1, 2);
    check(outs() == 5'b0, "R6", "single-cycle done", outs(), 0);
    pulse_start(1'b0, 2);
    for (int k = 0; k < 2; k++) begin
      if (shift_pulse) cnt++;
      @(negedge clk);
    end
    check(cnt == 2, "R6", "restart after done", cnt, 2);
    for (int k = 0; k < 6; k++) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_seq(1'b1, 3, 1'b0, "R3 los len3");
    t_seq(1'b0, 3, 1'b0, "R4 loc len3");
    t_seq(1'b1, 1, 1'b0, "R11 los len1");
    t_seq(1'b0, 1, 1'b0, "R11 loc len1");
    t_seq(1'b1, 3, 1'b1, "R7 los busy start");
    t_seq(1'b0, 3, 1'b1, "R7 loc busy start");
    t_seq(1'b0, 1023, 1'b0, "R11 loc len max");
    t_zero_len();
    t_test_off();
    t_back_to_back();
    t_async_reset();
    report();
  end
endmodule